// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Victim Selector

This block holds the replacement state of a single set in a four-way set-associative cache and names the way to evict on the next fill. The state is a three-node binary decision tree. A root node chooses between the lower pair of ways (0, 1) and the upper pair (2, 3), and one node under each half chooses between the two ways of that pair. Each node records which side was used more recently. The victim is found by following each node toward the side that was used less recently.

A way that holds no valid line is always a better victim than any valid one. When the valid vector shows a hole, the lowest-numbered empty way is named and the tree is not consulted. Each time the cache reports a hit or a fill through the reference strobe, the nodes on the path to that way are rewritten on the next clock edge so that they point away from it. Nodes off that path keep their values. The victim output is combinational, so the cache controller reads it in the same cycle it needs it. The strobe and the valid vector are plain control pins with no handshake.

Top module: `plru4_victim_sel`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets tree_bits to 3'b000. Bit 0 is the root node, bit 1 is the node over ways 0 and 1, and bit 2 is the node over ways 2 and 3.
- R2: With all four way_valid bits high and tree_bits[0] = 0, victim_way equals tree_bits[1] (way 0 when 0, way 1 when 1).
- R3: With all four way_valid bits high and tree_bits[0] = 1, victim_way equals 2 + tree_bits[2] (way 2 when 0, way 3 when 1).
- R4: If any way_valid bit (bit i for way i) is low, victim_way is the lowest index i whose way_valid[i] is low, whatever the tree holds.
- R5: A clock edge with ref_en high and ref_way = 0 sets tree_bits[0] and tree_bits[1] to 1 and leaves tree_bits[2] unchanged.
- R6: A clock edge with ref_en high and ref_way = 1 sets tree_bits[0] to 1 and tree_bits[1] to 0 and leaves tree_bits[2] unchanged.
- R7: A clock edge with ref_en high and ref_way = 2 sets tree_bits[0] to 0 and tree_bits[2] to 1 and leaves tree_bits[1] unchanged.
- R8: A clock edge with ref_en high and ref_way = 3 sets tree_bits[0] and tree_bits[2] to 0 and leaves tree_bits[1] unchanged.
- R9: A clock edge with ref_en low leaves tree_bits unchanged, whatever ref_way holds.
- R10: victim_way follows a change of way_valid in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | 1 | Reference strobe; the tree is updated at the edge where it is high |
| ref_way | input | 2 | Way that was hit or filled |
| way_valid | input | 4 | Valid bit of each way in the set, bit i for way i |
| victim_way | output | 2 | Way to replace next |
| tree_bits | output | 3 | Current tree node values |

## Verification
The assertions assume that ref_en, ref_way and way_valid carry known values whenever reset is low. They also assume that reset is held across at least one rising edge before the first reference. The bench meets these assumptions by giving every input a known value at time zero, by changing inputs only on the falling edge, and by holding reset for several cycles at the start. The expected tree state and victim come from a model in the bench that is written straight from the update and selection rules.

// File: rtl/plru4_pkg.sv
package plru4_pkg;
  localparam int NUM_WAYS   = 4;
  localparam int WAY_W      = $clog2(NUM_WAYS);
  localparam int TREE_W     = NUM_WAYS - 1;
  localparam int ROOT_NODE  = 0;
  localparam int LOW_NODE   = 1;
  localparam int HIGH_NODE  = 2;

  typedef logic [WAY_W-1:0]    way_idx_t;
  typedef logic [TREE_W-1:0]   tree_t;
  typedef logic [NUM_WAYS-1:0] way_vec_t;
endpackage

// File: rtl/plru4_tree_reg.sv
module plru4_tree_reg
  import plru4_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ref_en,
  input  way_idx_t ref_way,
  output tree_t    tree_q
);
  tree_t tree_d;
  logic  upper_half;
  logic  leaf_bit;

  assign upper_half = ref_way[WAY_W-1];
  assign leaf_bit   = ref_way[0];

  // Point every node on the referenced path away from the referenced way.
  always_comb begin
    tree_d = tree_q;
    if (ref_en) begin
      tree_d[ROOT_NODE] = ~upper_half;
      if (upper_half) tree_d[HIGH_NODE] = ~leaf_bit;
      else            tree_d[LOW_NODE]  = ~leaf_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tree_q <= '0;
    else     tree_q <= tree_d;
  end
endmodule

// File: rtl/plru4_tree_pick.sv
module plru4_tree_pick
  import plru4_pkg::*;
(
  input  tree_t    tree,
  output way_idx_t tree_victim
);
  // Follow each node toward the side used less recently.
  always_comb begin
    if (tree[ROOT_NODE]) tree_victim = {1'b1, tree[HIGH_NODE]};
    else                 tree_victim = {1'b0, tree[LOW_NODE]};
  end
endmodule

// File: rtl/plru4_first_free.sv
module plru4_first_free
  import plru4_pkg::*;
(
  input  way_vec_t way_valid,
  output logic     any_free,
  output way_idx_t free_way
);
  way_vec_t first_hole;

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_hole
    if (i == 0) begin : g_lowest
      assign first_hole[i] = ~way_valid[i];
    end else begin : g_upper
      assign first_hole[i] = ~way_valid[i] & (&way_valid[i-1:0]);
    end
  end

  assign any_free = |first_hole;

  always_comb begin
    free_way = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (first_hole[i]) free_way = way_idx_t'(i);
    end
  end
endmodule

// File: rtl/plru4_victim_sel.sv
module plru4_victim_sel
  import plru4_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_en,
  input  logic [WAY_W-1:0]    ref_way,
  input  logic [NUM_WAYS-1:0] way_valid,
  output logic [WAY_W-1:0]    victim_way,
  output logic [TREE_W-1:0]   tree_bits
);
  tree_t    tree_q;
  way_idx_t tree_victim;
  way_idx_t free_way;
  logic     any_free;

  plru4_tree_reg i_tree_reg (
    .clk    (clk),
    .rst    (rst),
    .ref_en (ref_en),
    .ref_way(ref_way),
    .tree_q (tree_q)
  );

  plru4_tree_pick i_tree_pick (
    .tree       (tree_q),
    .tree_victim(tree_victim)
  );

  plru4_first_free i_first_free (
    .way_valid(way_valid),
    .any_free (any_free),
    .free_way (free_way)
  );

  assign victim_way = any_free ? free_way : tree_victim;
  assign tree_bits  = tree_q;
endmodule

// File: rtl/plru4_victim_chk.sv
module plru4_victim_chk
  import plru4_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                ref_en,
  input logic [WAY_W-1:0]    ref_way,
  input logic [NUM_WAYS-1:0] way_valid,
  input logic [WAY_W-1:0]    victim_way,
  input logic [TREE_W-1:0]   tree_bits
);
  logic [NUM_WAYS-1:0] below_mask;
  assign below_mask = NUM_WAYS'((NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1));

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> tree_bits == '0); // R1
  AST_LOW_PAIR_PICK: assert property (@(posedge clk) disable iff (rst)
    (&way_valid && !tree_bits[0]) |-> victim_way == {1'b0, tree_bits[1]}); // R2
  AST_HIGH_PAIR_PICK: assert property (@(posedge clk) disable iff (rst)
    (&way_valid && tree_bits[0]) |-> victim_way == {1'b1, tree_bits[2]}); // R3
  AST_HOLE_FIRST: assert property (@(posedge clk) disable iff (rst)
    !(&way_valid) |-> (!way_valid[victim_way] && ((way_valid & below_mask) == below_mask))); // R4
  AST_REF_WAY0: assert property (@(posedge clk) disable iff (rst)
    (ref_en && ref_way == 2'd0) |=> (tree_bits[1:0] == 2'b11 && tree_bits[2] == $past(tree_bits[2]))); // R5
  AST_REF_WAY1: assert property (@(posedge clk) disable iff (rst)
    (ref_en && ref_way == 2'd1) |=> (tree_bits[1:0] == 2'b01 && tree_bits[2] == $past(tree_bits[2]))); // R6
  AST_REF_WAY2: assert property (@(posedge clk) disable iff (rst)
    (ref_en && ref_way == 2'd2) |=> (tree_bits[2] && !tree_bits[0] && tree_bits[1] == $past(tree_bits[1]))); // R7
  AST_REF_WAY3: assert property (@(posedge clk) disable iff (rst)
    (ref_en && ref_way == 2'd3) |=> (!tree_bits[2] && !tree_bits[0] && tree_bits[1] == $past(tree_bits[1]))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ref_en |=> $stable(tree_bits)); // R9
endmodule

bind plru4_victim_sel plru4_victim_chk i_victim_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_en    (ref_en),
  .ref_way   (ref_way),
  .way_valid (way_valid),
  .victim_way(victim_way),
  .tree_bits (tree_bits)
);

// File: tb/test_plru4_victim_sel.sv
module test_plru4_victim_sel;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_en = 1'b0;
  logic [1:0] ref_way = 2'd0;
  logic [3:0] way_valid = 4'hF;
  logic [1:0] victim_way;
  logic [2:0] tree_bits;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  logic [2:0] exp_tree = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;

  plru4_victim_sel i_plru4_victim_sel (
    .clk(clk), .rst(rst), .ref_en(ref_en), .ref_way(ref_way),
    .way_valid(way_valid), .victim_way(victim_way), .tree_bits(tree_bits)
  );

  function automatic logic [2:0] model_next(logic [2:0] t, logic [1:0] w);
    logic [2:0] n = t;
    case (w)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction

  function automatic logic [1:0] model_victim(logic [2:0] t, logic [3:0] v);
    for (int i = 0; i < 4; i++) if (!v[i]) return 2'(i);
    if (!t[0]) return {1'b0, t[1]};
    return {1'b1, t[2]};
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_ref(logic [1:0] w);
    @(negedge clk);
    ref_en = 1'b1; ref_way = w;
    @(posedge clk); #1;
    exp_tree = model_next(exp_tree, w);
    ref_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    #1; exp_tree = 3'b000;
    check("R1 tree after reset", {1'b0, tree_bits}, 4'h0);
    @(negedge clk); rst = 1'b0; way_valid = 4'hF;
    #1; check("R2 victim after reset", {2'b0, victim_way}, 4'h0);
  endtask

  task automatic t_ref_each_way();
    logic [1:0] seq [8] = '{2'd0, 2'd2, 2'd1, 2'd3, 2'd3, 2'd0, 2'd2, 2'd1};
    foreach (seq[k]) begin
      do_ref(seq[k]);
      case (seq[k])
        2'd0: check("R5 tree after ref way0", {1'b0, tree_bits}, {1'b0, exp_tree});
        2'd1: check("R6 tree after ref way1", {1'b0, tree_bits}, {1'b0, exp_tree});
        2'd2: check("R7 tree after ref way2", {1'b0, tree_bits}, {1'b0, exp_tree});
        default: check("R8 tree after ref way3", {1'b0, tree_bits}, {1'b0, exp_tree});
      endcase
      if (!exp_tree[0]) check("R2 victim low pair", {2'b0, victim_way}, {2'b0, model_victim(exp_tree, 4'hF)});
      else              check("R3 victim high pair", {2'b0, victim_way}, {2'b0, model_victim(exp_tree, 4'hF)});
    end
  endtask

  task automatic t_holes();
    logic [3:0] pats [8] = '{4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b0000, 4'b0110, 4'b0011, 4'b1100};
    do_ref(2'd0); // tree points at the upper half, holes must still win
    foreach (pats[k]) begin
      @(negedge clk); way_valid = pats[k];
      #1; check("R4 lowest empty way", {2'b0, victim_way}, {2'b0, model_victim(exp_tree, pats[k])});
    end
    @(negedge clk); way_valid = 4'hF;
    #1; check("R10 victim follows valid without edge", {2'b0, victim_way}, {2'b0, model_victim(exp_tree, 4'hF)});
    way_valid = 4'b1011;
    #1; check("R10 victim follows valid without edge", {2'b0, victim_way}, 4'h2);
    way_valid = 4'hF;
  endtask

  task automatic t_idle_hold();
    do_ref(2'd2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ref_en = 1'b0; ref_way = 2'(k);
      @(posedge clk); #1;
      check("R9 tree holds without strobe", {1'b0, tree_bits}, {1'b0, exp_tree});
    end
  endtask

  task automatic t_midrun_reset();
    do_ref(2'd1);
    @(negedge clk); rst = 1'b1; ref_en = 1'b1; ref_way = 2'd3;
    @(posedge clk); #1;
    exp_tree = 3'b000;
    check("R1 reset wins over strobe", {1'b0, tree_bits}, 4'h0);
    @(negedge clk); rst = 1'b0; ref_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all R actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ref_each_way();
    t_holes();
    t_idle_hold();
    t_midrun_reset();
    t_ref_each_way();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule